// File: doc/BRIEF.md
# Guarded Background Offset and Gain Calibration Loop

This block keeps an ADC's offset and gain coefficients tracking slow drift while conversion carries on. Each valid sample arrives with two signed error features, one for offset and one for gain, produced elsewhere from a reference or dither. When a trigger is accepted, the loop sums both features over a window of 2^K clock cycles. It then moves each coefficient by the window mean, scaled down by a programmable right shift (the step size mu). A second window of the same length measures the residual after the update.

Three guards protect the coefficients. A window that holds a clipped sample freezes the loop. So does a window with too few valid samples. An update whose residual comes out larger than the residual before it is undone, and the coefficients from before the update come back. While frozen, the coefficients are held and the loop keeps observing windows until one of them is clean. A minimum spacing between calibration runs keeps triggers that arrive during a transient from restarting the loop over and over.

Top module: `cal_bg_loop`

## Requirements
- R1: After reset, offset_coef is 0, gain_coef is 32768 (1.0 in Q1.15), loop_state is 0, freeze_code is 0 and rollback_pulse is 0.
- R2: In Idle (loop_state 0), a run starts on the next edge when temp_evt or perf_evt is high, or when cfg_frames is nonzero and at least cfg_frames frame_tick pulses have been counted since the last start. loop_state then reads 1 (Measure). With cfg_frames = 0 and no event, the loop stays in Idle.
- R3: A trigger is ignored unless at least cfg_min_gap cycles have passed since the loop last returned to Idle. A trigger that is ignored is not remembered.
- R4: A window lasts 2^K cycles, with K equal to cfg_win_log2 clamped to the range 4..12. After a clean Measure window the loop spends one cycle in Update (loop_state 2). At the end of that cycle each coefficient c becomes c - (S >>> (K + cfg_mu)), where S is the sum of that coefficient's error feature over the valid samples of the window and >>> is an arithmetic (floor) shift. The loop then enters Verify (loop_state 3).
- R5: offset_coef is signed 16-bit and saturates at -32768 and 32767. gain_coef is unsigned 16-bit and saturates at 0 and 65535. Neither wraps.
- R6: A valid sample equal to the most positive or the most negative SMP_W-bit code clips its window. A clipped Measure window leaves the coefficients unchanged, enters Freeze (loop_state 4) and sets freeze_code to 1.
- R7: A window with fewer than cfg_min_valid valid samples has low confidence. A low-confidence Measure window enters Freeze with freeze_code 2. Exactly cfg_min_valid valid samples pass. Clipping takes priority over low confidence.
- R8: The residual of a window is |S_off| + |S_gain|. If the Verify residual is larger than the Measure residual, the coefficients from before the update are restored, freeze_code becomes 3, rollback_pulse is high for one cycle and the loop returns to Idle. An equal or smaller residual keeps the update.
- R9: A Verify window that is clipped or has low confidence also restores the previous coefficients and pulses rollback_pulse. The loop then enters Freeze with freeze_code 1 or 2.
- R10: In Freeze the coefficients are held and windows repeat back to back. A window that fails a guard keeps the loop frozen, and the first clean window returns it to Idle.
- R11: freeze_code holds its value until reason_clr is pulsed, and stays in place through later successful runs. A new guard event in the same cycle as reason_clr takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample and error features valid this cycle |
| smp_data | input | SMP_W | Raw signed ADC sample, used for clip detection |
| off_err | input | ERR_W | Signed offset error feature |
| gain_err | input | ERR_W | Signed gain error feature |
| frame_tick | input | 1 | One pulse per frame, feeds the periodic trigger |
| temp_evt | input | 1 | Temperature-step trigger |
| perf_evt | input | 1 | Performance-degradation trigger |
| reason_clr | input | 1 | Clears freeze_code |
| cfg_win_log2 | input | 4 | Window length exponent K, clamped to 4..12 |
| cfg_mu | input | 4 | Extra right shift applied to the update step |
| cfg_frames | input | CNT_W | Frames between periodic runs, 0 disables them |
| cfg_min_gap | input | CNT_W | Minimum number of Idle cycles before a run may start |
| cfg_min_valid | input | KMAX+1 | Minimum number of valid samples in a window |
| offset_coef | output | COEF_W | Live signed offset coefficient |
| gain_coef | output | COEF_W | Live unsigned Q1.15 gain coefficient |
| loop_state | output | 3 | 0 Idle, 1 Measure, 2 Update, 3 Verify, 4 Freeze |
| freeze_code | output | 2 | 0 none, 1 clip, 2 low confidence, 3 rollback |
| rollback_pulse | output | 1 | One-cycle pulse when coefficients are restored |

## Verification
The update law is swept over window lengths, shift amounts and error values of both signs. Small negative means check that the shift floors rather than truncates, and extreme feature values drive both coefficients into each saturation limit. Verify windows with a larger, an equal and a smaller residual separate a rollback from a kept update. Windows clipped at the top and at the bottom code, and valid counts just below and exactly at the confidence limit, separate the two freeze reasons and test the boundary. Triggers sent during the spacing interval, frame counts and freeze windows that fail again before a clean one check the scheduling and the way out of Freeze.

// File: rtl/cal_pkg.sv
// Package: shared state and freeze-reason encodings for the calibration loop.
// Assumes: loop_state and freeze_code codes are visible at the ports as listed.
package cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MEAS   = 3'd1,
        ST_UPD    = 3'd2,
        ST_VERIFY = 3'd3,
        ST_FREEZE = 3'd4
    } cal_state_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_CLIP     = 2'd1,
        RSN_LOWCONF  = 2'd2,
        RSN_ROLLBACK = 2'd3
    } rsn_e;
endpackage

// File: rtl/cal_window.sv
// Observation window: sums both error features over 2^K cycles, counts valid
// samples and flags clipped samples. The *_n outputs include the current cycle,
// so the owner can decide in the last cycle of a window.
// Assumes: k_eff is already clamped to at most KMAX.
module cal_window #(
    parameter int SMP_W  = 12,
    parameter int ERR_W  = 16,
    parameter int ACC_W  = 29,
    parameter int WCNT_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     run,
    input  logic [3:0]               k_eff,
    input  logic                     smp_valid,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic signed [ERR_W-1:0]  off_err,
    input  logic signed [ERR_W-1:0]  gain_err,
    input  logic [WCNT_W-1:0]        min_valid,
    output logic                     win_last,
    output logic signed [ACC_W-1:0]  acc_off_q,
    output logic signed [ACC_W-1:0]  acc_gain_q,
    output logic signed [ACC_W-1:0]  sum_off_n,
    output logic signed [ACC_W-1:0]  sum_gain_n,
    output logic                     clip_n,
    output logic                     low_conf_n
);
    localparam logic signed [SMP_W-1:0] SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic signed [SMP_W-1:0] SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    logic [WCNT_W-1:0] win_cnt, vcnt_q, vcnt_n, win_end;
    logic              clip_q, take;

    // Purpose: form the window totals that include the sample of this cycle.
    always_comb begin
        take       = run && smp_valid;
        win_end    = (WCNT_W'(1) << k_eff) - WCNT_W'(1);
        win_last   = run && (win_cnt == win_end);
        sum_off_n  = acc_off_q  + (take ? {{(ACC_W-ERR_W){off_err[ERR_W-1]}},  off_err}  : '0);
        sum_gain_n = acc_gain_q + (take ? {{(ACC_W-ERR_W){gain_err[ERR_W-1]}}, gain_err} : '0);
        clip_n     = clip_q || (take && (smp_data == SMP_MAX || smp_data == SMP_MIN));
        vcnt_n     = vcnt_q + WCNT_W'(take);
        low_conf_n = vcnt_n < min_valid;
    end

    // Purpose: hold window totals; clear on restart, accumulate while running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            win_cnt    <= '0;
            vcnt_q     <= '0;
            clip_q     <= 1'b0;
            acc_off_q  <= '0;
            acc_gain_q <= '0;
        end else if (run) begin
            win_cnt    <= win_cnt + WCNT_W'(1);
            vcnt_q     <= vcnt_n;
            clip_q     <= clip_n;
            acc_off_q  <= sum_off_n;
            acc_gain_q <= sum_gain_n;
        end
    end
endmodule

// File: rtl/cal_sched.sv
// Trigger scheduler: merges the temperature, performance and periodic triggers
// and blocks them until the minimum spacing since the last run has passed.
// Assumes: triggers are sampled only while in_idle; ignored ones are dropped.
module cal_sched #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_idle,
    input  logic             clr_gap,
    input  logic             frame_tick,
    input  logic             temp_evt,
    input  logic             perf_evt,
    input  logic [CNT_W-1:0] cfg_frames,
    input  logic [CNT_W-1:0] cfg_min_gap,
    output logic             start,
    output logic             gap_ok
);
    logic [CNT_W-1:0] frame_cnt, gap_cnt;
    logic             periodic;

    // Purpose: decide whether a run starts on this edge.
    always_comb begin
        periodic = (cfg_frames != '0) && (frame_cnt >= cfg_frames);
        gap_ok   = gap_cnt >= cfg_min_gap;
        start    = in_idle && gap_ok && (temp_evt || perf_evt || periodic);
    end

    // Purpose: count frames since the last start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            frame_cnt <= '0;
        else if (frame_tick && frame_cnt != '1)
            frame_cnt <= frame_cnt + CNT_W'(1);
    end

    // Purpose: count cycles since the loop last returned to Idle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_gap)
            gap_cnt <= '0;
        else if (gap_cnt != '1)
            gap_cnt <= gap_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/cal_coef.sv
// Coefficient store: applies the shifted-error update law with saturation,
// keeps the pre-update copy and restores it on request.
// Assumes: apply and restore never assert in the same cycle.
module cal_coef #(
    parameter int COEF_W    = 16,
    parameter int ACC_W     = 29,
    parameter int SHW       = 5,
    parameter int OFF_INIT  = 0,
    parameter int GAIN_INIT = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply,
    input  logic                     restore,
    input  logic signed [ACC_W-1:0]  acc_off,
    input  logic signed [ACC_W-1:0]  acc_gain,
    input  logic [SHW-1:0]           shamt,
    output logic signed [COEF_W-1:0] offset_coef,
    output logic [COEF_W-1:0]        gain_coef
);
    localparam int EW = ACC_W + 1;
    localparam logic signed [EW-1:0] O_MAX = {{(EW-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
    localparam logic signed [EW-1:0] O_MIN = ~O_MAX;
    localparam logic signed [EW-1:0] G_MAX = {{(EW-COEF_W){1'b0}}, {COEF_W{1'b1}}};

    logic signed [EW-1:0]     step_o, step_g, cand_o, cand_g, sat_o, sat_g;
    logic signed [COEF_W-1:0] save_off;
    logic [COEF_W-1:0]        save_gain;

    // Purpose: scale the window error and saturate the candidate coefficients.
    always_comb begin
        step_o = {acc_off[ACC_W-1],  acc_off  >>> shamt};
        step_g = {acc_gain[ACC_W-1], acc_gain >>> shamt};
        cand_o = {{(EW-COEF_W){offset_coef[COEF_W-1]}}, offset_coef} - step_o;
        cand_g = {{(EW-COEF_W){1'b0}}, gain_coef} - step_g;
        sat_o  = (cand_o > O_MAX) ? O_MAX : (cand_o < O_MIN) ? O_MIN : cand_o;
        sat_g  = (cand_g > G_MAX) ? G_MAX : (cand_g < 0) ? '0 : cand_g;
    end

    // Purpose: live coefficients with update, save and restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_coef <= COEF_W'(OFF_INIT);
            gain_coef   <= COEF_W'(GAIN_INIT);
            save_off    <= COEF_W'(OFF_INIT);
            save_gain   <= COEF_W'(GAIN_INIT);
        end else if (apply) begin
            save_off    <= offset_coef;
            save_gain   <= gain_coef;
            offset_coef <= sat_o[COEF_W-1:0];
            gain_coef   <= sat_g[COEF_W-1:0];
        end else if (restore) begin
            offset_coef <= save_off;
            gain_coef   <= save_gain;
        end
    end
endmodule

// File: rtl/cal_bg_loop.sv
// Top: guarded background calibration controller. Sequences Idle, Measure,
// Update, Verify and Freeze, applies the guards, decides on rollback and
// latches the freeze reason.
// Assumes: the error features are already aligned with smp_data.
module cal_bg_loop
    import cal_pkg::*;
#(
    parameter int SMP_W     = 12,
    parameter int ERR_W     = 16,
    parameter int COEF_W    = 16,
    parameter int CNT_W     = 16,
    parameter int KMIN      = 4,
    parameter int KMAX      = 12,
    parameter int OFF_INIT  = 0,
    parameter int GAIN_INIT = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic signed [ERR_W-1:0]  off_err,
    input  logic signed [ERR_W-1:0]  gain_err,
    input  logic                     frame_tick,
    input  logic                     temp_evt,
    input  logic                     perf_evt,
    input  logic                     reason_clr,
    input  logic [3:0]               cfg_win_log2,
    input  logic [3:0]               cfg_mu,
    input  logic [CNT_W-1:0]         cfg_frames,
    input  logic [CNT_W-1:0]         cfg_min_gap,
    input  logic [KMAX:0]            cfg_min_valid,
    output logic signed [COEF_W-1:0] offset_coef,
    output logic [COEF_W-1:0]        gain_coef,
    output logic [2:0]               loop_state,
    output logic [1:0]               freeze_code,
    output logic                     rollback_pulse
);
    localparam int ACC_W  = ERR_W + KMAX + 1;
    localparam int WCNT_W = KMAX + 1;
    localparam int MET_W  = ACC_W + 1;
    localparam int SHW    = 5;

    cal_state_e             st, nxt;
    rsn_e                   rsn_q, new_rsn, guard_rsn;
    logic                   set_rsn, restore, guard_bad, start, gap_ok, run, restart, clr_gap;
    logic                   win_last, clip_n, low_conf_n;
    logic [3:0]             k_eff;
    logic [SHW-1:0]         shamt;
    logic signed [ACC_W-1:0] acc_off_q, acc_gain_q, sum_off_n, sum_gain_n, mag_o, mag_g;
    logic [MET_W-1:0]       metric_n, pre_metric;

    // Purpose: clamp K and form the total shift of the update law.
    always_comb begin
        if (cfg_win_log2 < 4'(KMIN))      k_eff = 4'(KMIN);
        else if (cfg_win_log2 > 4'(KMAX)) k_eff = 4'(KMAX);
        else                              k_eff = cfg_win_log2;
        shamt = {1'b0, k_eff} + {1'b0, cfg_mu};
    end

    // Purpose: residual metric of the window ending in this cycle.
    always_comb begin
        mag_o    = sum_off_n[ACC_W-1]  ? -sum_off_n  : sum_off_n;
        mag_g    = sum_gain_n[ACC_W-1] ? -sum_gain_n : sum_gain_n;
        metric_n = {1'b0, mag_o} + {1'b0, mag_g};
    end

    // Purpose: next state, guard outcome, rollback and reason selection.
    always_comb begin
        nxt       = st;
        set_rsn   = 1'b0;
        restore   = 1'b0;
        guard_bad = clip_n || low_conf_n;
        guard_rsn = clip_n ? RSN_CLIP : RSN_LOWCONF;
        new_rsn   = guard_rsn;
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_MEAS;
            ST_MEAS:   if (win_last) begin
                           if (guard_bad) begin nxt = ST_FREEZE; set_rsn = 1'b1; end
                           else nxt = ST_UPD;
                       end
            ST_UPD:    nxt = ST_VERIFY;
            ST_VERIFY: if (win_last) begin
                           if (guard_bad) begin
                               nxt = ST_FREEZE; set_rsn = 1'b1; restore = 1'b1;
                           end else if (metric_n > pre_metric) begin
                               nxt = ST_IDLE; set_rsn = 1'b1; restore = 1'b1;
                               new_rsn = RSN_ROLLBACK;
                           end else nxt = ST_IDLE;
                       end
            ST_FREEZE: if (win_last) begin
                           if (guard_bad) set_rsn = 1'b1;
                           else nxt = ST_IDLE;
                       end
            default:   nxt = ST_IDLE;
        endcase
        run     = (st == ST_MEAS) || (st == ST_VERIFY) || (st == ST_FREEZE);
        restart = start || (st == ST_UPD) || (win_last && nxt == ST_FREEZE);
        clr_gap = (st != ST_IDLE) && (nxt == ST_IDLE);
    end

    // Purpose: state, pre-update residual, reason latch and rollback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st             <= ST_IDLE;
            rsn_q          <= RSN_NONE;
            pre_metric     <= '0;
            rollback_pulse <= 1'b0;
        end else begin
            st             <= nxt;
            rollback_pulse <= restore;
            if (st == ST_MEAS && win_last) pre_metric <= metric_n;
            if (set_rsn)         rsn_q <= new_rsn;
            else if (reason_clr) rsn_q <= RSN_NONE;
        end
    end

    assign loop_state  = st;
    assign freeze_code = rsn_q;

    cal_sched #(.CNT_W(CNT_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .in_idle(st == ST_IDLE), .clr_gap(clr_gap),
        .frame_tick(frame_tick), .temp_evt(temp_evt), .perf_evt(perf_evt),
        .cfg_frames(cfg_frames), .cfg_min_gap(cfg_min_gap),
        .start(start), .gap_ok(gap_ok)
    );

    cal_window #(.SMP_W(SMP_W), .ERR_W(ERR_W), .ACC_W(ACC_W), .WCNT_W(WCNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .k_eff(k_eff),
        .smp_valid(smp_valid), .smp_data(smp_data), .off_err(off_err), .gain_err(gain_err),
        .min_valid(cfg_min_valid), .win_last(win_last),
        .acc_off_q(acc_off_q), .acc_gain_q(acc_gain_q),
        .sum_off_n(sum_off_n), .sum_gain_n(sum_gain_n),
        .clip_n(clip_n), .low_conf_n(low_conf_n)
    );

    cal_coef #(.COEF_W(COEF_W), .ACC_W(ACC_W), .SHW(SHW),
               .OFF_INIT(OFF_INIT), .GAIN_INIT(GAIN_INIT)) u_coef (
        .clk(clk), .rst_n(rst_n), .apply(st == ST_UPD), .restore(restore),
        .acc_off(acc_off_q), .acc_gain(acc_gain_q), .shamt(shamt),
        .offset_coef(offset_coef), .gain_coef(gain_coef)
    );
endmodule

// File: rtl/cal_bg_loop_chk.sv
// Checker: temporal properties of the calibration loop, bound to the top.
// Assumes: loop_state codes 0 Idle, 1 Measure, 2 Update, 3 Verify, 4 Freeze.
module cal_bg_loop_chk #(
    parameter int COEF_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        state,
    input logic [COEF_W-1:0] off_c,
    input logic [COEF_W-1:0] gain_c,
    input logic              pulse,
    input logic [1:0]        code,
    input logic              clr,
    input logic              temp_evt,
    input logic              perf_evt,
    input logic [CNT_W-1:0]  frames,
    input logic              gap_ok
);
    // R2: with no trigger source the loop stays in Idle
    assert_no_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && !temp_evt && !perf_evt && frames == '0) |=> state == 3'd0);

    // R3: spacing not yet reached keeps Idle
    assert_gap_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && !gap_ok) |=> state == 3'd0);

    // R4: Update lasts exactly one cycle and leads to Verify
    assert_upd_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd2 |=> state == 3'd3);

    // R10: coefficients only move out of Update or Verify
    assert_coef_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 || state == 3'd1 || state == 3'd4) |=> ($stable(off_c) && $stable(gain_c)));

    // R8: a rollback pulse follows a Verify cycle and lasts one cycle
    assert_pulse_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(state) == 3'd3);
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R6: entering Freeze always carries a guard reason (R7 covers code 2)
    assert_freeze_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && $past(state) != 3'd4) |-> (code == 2'd1 || code == 2'd2));

    // R11: a latched reason survives until cleared
    assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 2'd0 && !clr) |=> code != 2'd0);
endmodule

bind cal_bg_loop cal_bg_loop_chk #(.COEF_W(COEF_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(loop_state), .off_c(offset_coef), .gain_c(gain_coef),
    .pulse(rollback_pulse), .code(freeze_code), .clr(reason_clr),
    .temp_evt(temp_evt), .perf_evt(perf_evt), .frames(cfg_frames), .gap_ok(gap_ok)
);

// File: tb/tb_cal_bg_loop.sv
// Bench: drives windows of constant error features and computes the expected
// coefficients, states and reasons arithmetically.
module tb_cal_bg_loop;
    logic               clk = 1'b0, rst_n = 1'b0;
    logic               smp_valid = 1'b0, frame_tick = 1'b0, temp_evt = 1'b0, perf_evt = 1'b0;
    logic               reason_clr = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic signed [15:0] off_err = '0, gain_err = '0;
    logic [3:0]         cfg_win_log2 = 4'd4, cfg_mu = 4'd0;
    logic [15:0]        cfg_frames = '0, cfg_min_gap = '0;
    logic [12:0]        cfg_min_valid = 13'd4;
    logic signed [15:0] offset_coef;
    logic [15:0]        gain_coef;
    logic [2:0]         loop_state;
    logic [1:0]         freeze_code;
    logic               rollback_pulse;

    int checks = 0, errors = 0;
    int m_off = 0, m_gain = 32768, m_code = 0;

    always #5 clk = ~clk;

    cal_bg_loop dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .off_err(off_err), .gain_err(gain_err), .frame_tick(frame_tick),
        .temp_evt(temp_evt), .perf_evt(perf_evt), .reason_clr(reason_clr),
        .cfg_win_log2(cfg_win_log2), .cfg_mu(cfg_mu), .cfg_frames(cfg_frames),
        .cfg_min_gap(cfg_min_gap), .cfg_min_valid(cfg_min_valid),
        .offset_coef(offset_coef), .gain_coef(gain_coef), .loop_state(loop_state),
        .freeze_code(freeze_code), .rollback_pulse(rollback_pulse)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_s(input longint v);
        return (v > 32767) ? 32767 : (v < -32768) ? -32768 : int'(v);
    endfunction

    function automatic int sat_u(input longint v);
        return (v > 65535) ? 65535 : (v < 0) ? 0 : int'(v);
    endfunction

    function automatic int keff(input int c);
        return (c < 4) ? 4 : (c > 12) ? 12 : c;
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk_coefs(input string req);
        chk({req, " offset"}, longint'(offset_coef), m_off);
        chk({req, " gain"}, longint'(gain_coef), m_gain);
    endtask

    // clip: 0 none, 1 top code on the first sample, 2 bottom code on the first sample
    task automatic drive_win(input int len, input int eo, input int eg, input int nv, input int clip);
        for (int i = 0; i < len; i++) begin
            smp_valid = (i < nv);
            smp_data  = (clip == 1 && i == 0) ? 12'sd2047 : (clip == 2 && i == 0) ? -12'sd2048 : 12'sd100;
            off_err   = 16'(eo);
            gain_err  = 16'(eg);
            tick();
        end
        smp_valid = 1'b0; off_err = '0; gain_err = '0; smp_data = '0;
    endtask

    // trig: 0 temperature, 1 performance
    task automatic cal_run(input string req, input int cfgk, input int mu, input int trig,
                           input int eo_m, input int eg_m, input int nv_m, input int clip_m,
                           input int eo_v, input int eg_v, input int nv_v);
        int k, len, old_off, old_gain;
        longint pre, post;
        k = keff(cfgk); len = 1 << k;
        cfg_win_log2 = 4'(cfgk); cfg_mu = 4'(mu);
        if (trig == 0) temp_evt = 1'b1; else perf_evt = 1'b1;
        tick();
        temp_evt = 1'b0; perf_evt = 1'b0;
        chk({req, " R2 start"}, loop_state, 1);
        drive_win(len, eo_m, eg_m, nv_m, clip_m);
        if (clip_m != 0 || nv_m < int'(cfg_min_valid)) begin
            m_code = (clip_m != 0) ? 1 : 2;
            chk({req, " R6/R7 freeze state"}, loop_state, 4);
            chk({req, " R6/R7 freeze code"}, freeze_code, m_code);
            chk_coefs({req, " R6 held"});
            return;
        end
        chk({req, " R4 window length"}, loop_state, 2);
        tick();
        old_off = m_off; old_gain = m_gain;
        m_off  = sat_s(longint'(m_off)  - ((longint'(eo_m) * nv_m) >>> (k + mu)));
        m_gain = sat_u(longint'(m_gain) - ((longint'(eg_m) * nv_m) >>> (k + mu)));
        chk({req, " R4 verify state"}, loop_state, 3);
        chk_coefs({req, " R4/R5 update"});
        drive_win(len, eo_v, eg_v, nv_v, 0);
        pre  = absl(longint'(eo_m) * nv_m) + absl(longint'(eg_m) * nv_m);
        post = absl(longint'(eo_v) * nv_v) + absl(longint'(eg_v) * nv_v);
        if (nv_v < int'(cfg_min_valid)) begin
            m_off = old_off; m_gain = old_gain; m_code = 2;
            chk({req, " R9 state"}, loop_state, 4);
            chk({req, " R9 pulse"}, rollback_pulse, 1);
        end else if (post > pre) begin
            m_off = old_off; m_gain = old_gain; m_code = 3;
            chk({req, " R8 state"}, loop_state, 0);
            chk({req, " R8 pulse"}, rollback_pulse, 1);
        end else begin
            chk({req, " R8 keep state"}, loop_state, 0);
            chk({req, " R8 no pulse"}, rollback_pulse, 0);
        end
        chk({req, " R11 code"}, freeze_code, m_code);
        chk_coefs({req, " R8 after verify"});
    endtask

    task automatic freeze_win(input string req, input int nv, input int clip, input int exp_state);
        drive_win(1 << keff(int'(cfg_win_log2)), 0, 0, nv, clip);
        if (exp_state == 4) m_code = (clip != 0) ? 1 : 2;
        chk({req, " R10 state"}, loop_state, exp_state);
        chk({req, " R11 code"}, freeze_code, m_code);
        chk_coefs({req, " R10 held"});
    endtask

    task automatic clear_code();
        reason_clr = 1'b1; tick(); reason_clr = 1'b0;
        m_code = 0;
        chk("R11 clear", freeze_code, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 state", loop_state, 0);
        chk("R1 code", freeze_code, 0);
        chk("R1 pulse", rollback_pulse, 0);
        chk_coefs("R1 reset");

        cal_run("basic", 4, 1, 0, 32, -16, 16, 0, 0, 0, 16);
        cal_run("perf", 4, 0, 1, 8, 8, 16, 0, 0, 0, 16);
        cal_run("worse", 4, 0, 0, 2, 0, 16, 0, 3, 0, 16);
        cal_run("equal", 4, 0, 0, 2, 0, 16, 0, -2, 0, 16);
        clear_code();

        cal_run("clip top", 4, 0, 0, 50, 50, 16, 1, 0, 0, 16);
        freeze_win("clip again", 16, 2, 4);
        freeze_win("clean", 16, 0, 0);
        clear_code();
        cal_run("clip bottom", 4, 0, 1, 50, 50, 16, 2, 0, 0, 16);
        freeze_win("clean2", 16, 0, 0);

        cfg_min_valid = 13'd10;
        cal_run("lowconf", 4, 0, 0, 40, 0, 9, 0, 0, 0, 16);
        freeze_win("lowconf again", 9, 0, 4);
        freeze_win("lowconf edge", 10, 0, 0);
        cal_run("R7 boundary", 4, 0, 0, 40, 0, 10, 0, 0, 0, 10);
        cal_run("R9 verify lowconf", 4, 0, 0, 40, 40, 16, 0, 0, 0, 5);
        freeze_win("R9 exit", 16, 0, 0);
        clear_code();
        cfg_min_valid = 13'd4;

        // R5: saturation at both ends of both coefficients
        cal_run("R5 up1", 4, 0, 0, -32768, -32768, 16, 0, 0, 0, 16);
        cal_run("R5 up2", 4, 0, 0, -32768, -32768, 16, 0, 0, 0, 16);
        for (int i = 0; i < 3; i++) cal_run("R5 down", 4, 0, 0, 32767, 32767, 16, 0, 0, 0, 16);

        // R3: triggers inside the spacing are dropped
        cfg_min_gap = 16'd40;
        temp_evt = 1'b1; tick(); temp_evt = 1'b0;
        chk("R3 blocked", loop_state, 0);
        perf_evt = 1'b1; repeat (5) tick(); perf_evt = 1'b0;
        chk("R3 blocked perf", loop_state, 0);
        repeat (40) tick();
        chk("R3 not remembered", loop_state, 0);
        cal_run("R3 after gap", 4, 0, 0, 16, 0, 16, 0, 0, 0, 16);
        cfg_min_gap = 16'd0;

        // R2: periodic trigger after cfg_frames frame ticks
        cfg_frames = 16'd3;
        for (int i = 0; i < 2; i++) begin
            frame_tick = 1'b1; tick(); frame_tick = 1'b0; tick();
        end
        chk("R2 two frames idle", loop_state, 0);
        frame_tick = 1'b1; tick(); frame_tick = 1'b0;
        tick();
        chk("R2 periodic start", loop_state, 1);
        cfg_frames = 16'd0;
        drive_win(16, 0, 0, 16, 0);
        tick();
        drive_win(16, 0, 0, 16, 0);
        chk("R2 periodic done", loop_state, 0);
        chk_coefs("R2 periodic zero error");

        // R4: clamp of K
        cal_run("R4 clamp low", 0, 0, 0, 16, 16, 16, 0, 0, 0, 16);
        cal_run("R4 clamp high", 15, 2, 0, 5, -7, 4096, 0, 0, 0, 4096);

        // R4: sweep of window length, shift and error sign
        for (int k = 4; k <= 6; k++)
            for (int mu = 0; mu <= 3; mu++)
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 2; b++)
                        cal_run("R4 sweep", k, mu, (a + b) % 2,
                                (a == 0) ? -300 : (a == 1) ? -1 : 77,
                                (b == 0) ? 5 : -40, 1 << k, 0, 0, 0, 1 << k);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule